// File: doc/BRIEF.md
# Dual-Mode Host Bus Port with Burst-Paced Stream FIFO

This block connects a small microcontroller to a media decoder. The host uses a 4-bit address, an 8-bit data bus, an active-low chip select and two strobe pins. A static mode input sets what the two strobe pins mean. With the mode low, pin A is a read/write direction line (low means write) and pin B is an active-low data strobe. With the mode high, pin A is an active-low write strobe and pin B is an active-low read strobe.

Bytes written to the stream address go into an internal byte FIFO. The decoder drains the FIFO through a simple pop interface. Stream writes are paced by a three-state ready pin:
- **Driven high:** the host may send one burst, whose length is set in a register.
- **Driven low:** the host must wait.
- **Released:** the pin floats from the first byte of a burst until its last byte.

The chip select and strobes pass through a two-flop synchronizer. Each access takes effect once, on the asserting edge of its strobe.

Top module: `hostbus_port`

## Requirements
- R1: With `mode_sep` high, pin A low with `cs_n` low is a write and pin B low with `cs_n` low is a read. The burst-length register at address 0x1 reads back the last value written to it; its reset value is 4.
- R2: With `mode_sep` low, pin A is a direction line (low = write, high = read) and pin B low is the data strobe. Register writes and reads behave as in R1.
- R3: A strobe given while `cs_n` is high has no effect on any register or on the FIFO.
- R4: After reset the FIFO is empty and the ready pin is driven high (`rdy_oe`=1, `rdy_val`=1), because the FIFO has room for a burst.
- R5: The first stream write (address 0x0) made while ready is driven high releases the pin (`rdy_oe`=0). The pin stays released until the number of accepted stream bytes equals the burst length.
- R6: When a burst ends, the pin is driven again. It is driven high only if free FIFO space is at least the burst length; otherwise it is driven low. It returns high once pops make enough room.
- R7: Address 0x2 reads the FIFO level. Every address other than 0x1, 0x2 and 0x3 reads zero, including the stream port 0x0.
- R8: A stream write while the FIFO is full is dropped and sets the sticky overflow flag, bit 0 of address 0x3. Writing 1 to that bit clears the flag.
- R9: Bytes leave on `pop_data` in the order they were written. `pop_empty` is high when no byte is held.
- R10: A strobe held for many cycles performs exactly one access.
- R11: A burst length of zero acts as a burst length of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sep | input | 1 | Strobe style: 1 = separate write/read strobes, 0 = direction plus data strobe |
| cs_n | input | 1 | Active-low chip select |
| pin_a_n | input | 1 | Write strobe (mode 1) or read/write direction (mode 0) |
| pin_b_n | input | 1 | Read strobe (mode 1) or data strobe (mode 0) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Data captured by the most recent read |
| rdata_oe | output | 1 | High while a read access is active |
| rdy_val | output | 1 | Value driven on the ready pin |
| rdy_oe | output | 1 | Ready pin driver enable; 0 means released to the pull-up |
| pop | input | 1 | Decoder takes the head byte |
| pop_data | output | 8 | Head byte of the FIFO |
| pop_empty | output | 1 | FIFO holds no byte |

## Verification
Register traffic is run in both strobe styles, plus once with chip select high. This separates correct strobe decoding from a swapped or ungated decode. Stream traffic is sent as whole bursts until the FIFO fills, followed by one extra byte. This separates the three ready-pin states, the end-of-burst room test and the drop-on-full path. A long-held strobe and a zero burst length then check single-event edge detection and the length clamp. Draining the FIFO checks byte order and the return of ready as room reappears.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int ADDR_STREAM = 0;
  localparam int ADDR_BLEN   = 1;
  localparam int ADDR_LEVEL  = 2;
  localparam int ADDR_FLAGS  = 3;

  typedef enum logic [1:0] {RDY_LOW, RDY_HIGH, RDY_FLOAT} rdy_st_t;

  // burst length actually used: a zero setting means one byte
  function automatic int eff_len(input int len);
    return (len == 0) ? 1 : len;
  endfunction

  // true when the FIFO can take a whole burst
  function automatic int has_room(input int level, input int len, input int depth);
    return ((depth - level) >= len) ? 1 : 0;
  endfunction
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/hbp_strobe_dec.sv
module hbp_strobe_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sep,
  input  logic cs_s,
  input  logic a_s,
  input  logic b_s,
  output logic wr_evt,
  output logic rd_evt,
  output logic rd_act
);
  logic wr_lvl, rd_lvl, wr_q, rd_q;

  always_comb begin
    if (mode_sep) begin
      wr_lvl = !cs_s && !a_s;
      rd_lvl = !cs_s && !b_s;
    end else begin
      wr_lvl = !cs_s && !b_s && !a_s;
      rd_lvl = !cs_s && !b_s && a_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_lvl;
      rd_q <= rd_lvl;
    end
  end

  assign wr_evt = wr_lvl && !wr_q;
  assign rd_evt = rd_lvl && !rd_q;
  assign rd_act = rd_lvl;
endmodule

// File: rtl/hbp_fifo.sv
module hbp_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head  = mem[rp];
  assign empty = (level == '0);
  assign full  = (int'(level) == DEPTH);
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
  import hbp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter logic [DW-1:0] BLEN_RST = 8'd4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sep,
  input  logic          cs_n,
  input  logic          pin_a_n,
  input  logic          pin_b_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          rdy_val,
  output logic          rdy_oe,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          pop_empty
);
  logic [2:0] pins_s;
  logic wr_evt, rd_evt, rd_act;
  logic stream_wr, push, pop_ok, full, ovf;
  logic [LW-1:0] level;
  logic [DW-1:0] blen, burst_cnt;
  int len_i;
  logic room;
  rdy_st_t st;

  hbp_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, pin_a_n, pin_b_n}), .q(pins_s));

  hbp_strobe_dec u_dec (
    .clk(clk), .rst_n(rst_n), .mode_sep(mode_sep),
    .cs_s(pins_s[2]), .a_s(pins_s[1]), .b_s(pins_s[0]),
    .wr_evt(wr_evt), .rd_evt(rd_evt), .rd_act(rd_act));

  assign stream_wr = wr_evt && (int'(addr) == ADDR_STREAM);
  assign push      = stream_wr && !full;
  assign pop_ok    = pop && !pop_empty;

  hbp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(wdata),
    .pop(pop_ok), .head(pop_data), .empty(pop_empty), .full(full),
    .level(level));

  assign len_i = eff_len(int'(blen));
  assign room  = has_room(int'(level), len_i, DEPTH) != 0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen  <= BLEN_RST;
      ovf   <= 1'b0;
      rdata <= '0;
    end else begin
      if (wr_evt && int'(addr) == ADDR_BLEN) blen <= wdata;
      if (stream_wr && full) ovf <= 1'b1;
      else if (wr_evt && int'(addr) == ADDR_FLAGS && wdata[0]) ovf <= 1'b0;
      if (rd_evt) begin
        case (int'(addr))
          ADDR_BLEN:  rdata <= blen;
          ADDR_LEVEL: rdata <= DW'(level);
          ADDR_FLAGS: rdata <= DW'(ovf);
          default:    rdata <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RDY_LOW;
      burst_cnt <= '0;
    end else begin
      case (st)
        RDY_LOW: if (room) st <= RDY_HIGH;
        RDY_HIGH: begin
          if (push) begin
            if (len_i == 1) st <= RDY_LOW;
            else begin
              st        <= RDY_FLOAT;
              burst_cnt <= DW'(1);
            end
          end else if (!room) st <= RDY_LOW;
        end
        RDY_FLOAT: begin
          if (push) begin
            if (int'(burst_cnt) + 1 >= len_i) begin
              st        <= RDY_LOW;
              burst_cnt <= '0;
            end else burst_cnt <= burst_cnt + 1'b1;
          end
        end
        default: st <= RDY_LOW;
      endcase
    end
  end

  assign rdy_val  = (st == RDY_HIGH);
  assign rdy_oe   = (st != RDY_FLOAT);
  assign rdata_oe = rd_act;
endmodule

// File: rtl/hbp_port_chk.sv
module hbp_port_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_evt,
  input logic          rd_evt,
  input logic          stream_wr,
  input logic          full,
  input logic          pop_ok,
  input logic          ovf,
  input logic          rdy_val,
  input logic          rdy_oe,
  input logic [LW-1:0] level,
  input logic [DW-1:0] burst_cnt,
  input int            len_i,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata
);
  a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
  a_r10_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> !rd_evt);
  a_r8_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_wr && full && !pop_ok) |=> $stable(level));
  a_r8_sticky_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(stream_wr && full));
  a_r6_room_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_val) |-> ($past(DEPTH - int'(level)) >= $past(len_i)));
  a_r5_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_oe |-> (int'(burst_cnt) < len_i));
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && int'(addr) > 3) |=> (rdata == '0));
endmodule

bind hostbus_port hbp_port_chk #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .rd_evt(rd_evt),
  .stream_wr(stream_wr), .full(full), .pop_ok(pop_ok), .ovf(ovf),
  .rdy_val(rdy_val), .rdy_oe(rdy_oe), .level(level), .burst_cnt(burst_cnt),
  .len_i(len_i), .addr(addr), .rdata(rdata));

// File: tb/sim_hostbus_port.sv
`timescale 1ns/1ps
module sim_hostbus_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sep = 1'b1;
  logic cs_n = 1'b1, pin_a_n = 1'b1, pin_b_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pop_data;
  logic rdata_oe, rdy_val, rdy_oe, pop_empty;
  logic pop = 1'b0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hostbus_port u0 (
    .clk(clk), .rst_n(rst_n), .mode_sep(mode_sep), .cs_n(cs_n),
    .pin_a_n(pin_a_n), .pin_b_n(pin_b_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .rdy_val(rdy_val), .rdy_oe(rdy_oe),
    .pop(pop), .pop_data(pop_data), .pop_empty(pop_empty));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one host access; hold = strobe-low cycles; sel = drive chip select
  task automatic acc(input bit is_wr, input logic [3:0] a, input logic [7:0] d,
                     input int hold, input bit sel);
    @(negedge clk);
    addr = a; wdata = d; cs_n = !sel;
    if (!mode_sep) pin_a_n = !is_wr;
    @(negedge clk);
    if (mode_sep) begin
      if (is_wr) pin_a_n = 1'b0; else pin_b_n = 1'b0;
    end else pin_b_n = 1'b0;
    repeat (hold) @(negedge clk);
    pin_a_n = 1'b1; pin_b_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    acc(1'b1, a, d, 4, 1'b1);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    acc(1'b0, a, 8'h00, 4, 1'b1);
    d = rdata;
  endtask

  task automatic pop_one(output logic [7:0] d);
    @(negedge clk);
    d = pop_data;
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk("R4 empty", int'(pop_empty), 1);
    chk("R4 rdy_oe", int'(rdy_oe), 1);
    chk("R4 rdy_val", int'(rdy_val), 1);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    mode_sep = 1'b1;
    rd(4'h1, v); chk("R1 blen reset", int'(v), 4);
    wr(4'h1, 8'd7); rd(4'h1, v); chk("R1 blen sep mode", int'(v), 7);
    mode_sep = 1'b0;
    wr(4'h1, 8'd5); rd(4'h1, v); chk("R2 blen dir mode", int'(v), 5);
    acc(1'b1, 4'h1, 8'd9, 4, 1'b0);
    rd(4'h1, v); chk("R3 cs high ignored", int'(v), 5);
    wr(4'h1, 8'd4);
    mode_sep = 1'b1;
  endtask

  task automatic t_burst;
    logic [7:0] v;
    wr(4'h0, 8'h10);
    chk("R5 released on first byte", int'(rdy_oe), 0);
    wr(4'h0, 8'h11); wr(4'h0, 8'h12);
    chk("R5 still released", int'(rdy_oe), 0);
    wr(4'h0, 8'h13);
    chk("R6 driven after burst", int'(rdy_oe), 1);
    chk("R6 high with room", int'(rdy_val), 1);
    rd(4'h2, v); chk("R7 level", int'(v), 4);
  endtask

  task automatic t_fill;
    logic [7:0] v;
    mode_sep = 1'b0;
    for (int i = 0; i < 12; i++) wr(4'h0, 8'h20 + 8'(i));
    chk("R6 driven low when full", int'(rdy_oe), 1);
    chk("R6 low value", int'(rdy_val), 0);
    wr(4'h0, 8'hEE);
    rd(4'h2, v); chk("R8 level stays full", int'(v), 16);
    rd(4'h3, v); chk("R8 overflow set", int'(v), 1);
    wr(4'h3, 8'h01);
    rd(4'h3, v); chk("R8 overflow cleared", int'(v), 0);
    mode_sep = 1'b1;
  endtask

  task automatic t_drain;
    logic [7:0] v, exp;
    for (int i = 0; i < 16; i++) begin
      pop_one(v);
      exp = (i < 4) ? 8'h10 + 8'(i) : 8'h20 + 8'(i - 4);
      chk("R9 order", int'(v), int'(exp));
      if (i == 3) begin
        repeat (3) @(negedge clk);
        chk("R6 high again after pops", int'(rdy_val), 1);
      end
    end
    @(negedge clk);
    chk("R9 empty", int'(pop_empty), 1);
  endtask

  task automatic t_hold;
    logic [7:0] v;
    acc(1'b1, 4'h0, 8'h55, 20, 1'b1);
    rd(4'h2, v); chk("R10 one byte per strobe", int'(v), 1);
    wr(4'h0, 8'h56); wr(4'h0, 8'h57); wr(4'h0, 8'h58);
    chk("R10 burst closes", int'(rdy_val), 1);
  endtask

  task automatic t_zero;
    logic [7:0] v;
    wr(4'h1, 8'd0);
    rd(4'h1, v); chk("R11 blen reads 0", int'(v), 0);
    wr(4'h0, 8'h60);
    chk("R11 single-byte burst", int'(rdy_oe), 1);
    chk("R11 ready high", int'(rdy_val), 1);
    rd(4'h2, v); chk("R11 level", int'(v), 5);
  endtask

  task automatic t_unused;
    logic [7:0] v;
    rd(4'hA, v); chk("R7 unused reads 0", int'(v), 0);
    rd(4'h0, v); chk("R7 stream port reads 0", int'(v), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_burst();
    t_fill();
    t_drain();
    t_hold();
    t_zero();
    t_unused();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule